// File: doc/BRIEF.md
# Packet-Granular Output Arbiter

This block sits at one output of a router that keeps its flits in elastic-buffer channels instead of virtual-channel buffers. One copy is placed per output, and it stands in for the separate channel and switch allocators a buffered router would need. Each input presents a request line, which is asserted when that input's synchronizer has chosen this output for its next packet. Each input also presents a one-cycle update pulse, which marks the departure of that input's tail flit.

The arbiter keeps a registered one-hot grant. The grant names the input that owns the output for the whole of a packet. Arbitration is therefore finished a cycle before any flit of the packet crosses the switch. In the cycle a flit is present, it moves as soon as its input is granted, its data is valid and the output can accept it.

The grant is re-evaluated only in two cases. The first is at the edge after the granted input signals tail departure. The second is when no grant is held at all. Choice among the requesters is round-robin, starting just past the input that won last.

Top module: `pkt_output_arbiter`

## Requirements
- R1: A synchronous reset clears the grant to all zeros and places the round-robin start position at input 0. After reset, with every input requesting, input 0 wins.
- R2: The grant is NUM_IN bits wide, and bit i selects input i. At most one bit is ever set.
- R3: While no grant is held, any asserted request loads a grant at the next clock edge. No update is needed for this.
- R4: A new grant goes to the first requesting input found by scanning upward, with wrap-around, from the position one past the input granted most recently.
- R5: While a grant is held and its holder sends no update, the grant stays unchanged at every edge, whatever the request lines do.
- R6: Update pulses from inputs other than the current holder have no effect on the grant.
- R7: An update from the holder causes re-arbitration among the requests present in that same cycle. The result is registered at the next edge, and the former holder has the lowest priority.
- R8: An update from the holder while no input requests clears the grant to all zeros at the next edge.
- R9: In the same cycle, xfer bit i is high exactly when grant bit i, in_valid bit i and out_ready are all high.
- R10: The round-robin start position changes only when a grant is loaded. Going idle leaves it in place, so the next pick continues from one past the last winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_IN | Per-input request for this output |
| upd | input | NUM_IN | Per-input tail-departure pulse |
| in_valid | input | NUM_IN | Per-input flit present in the intermediate buffer |
| out_ready | input | 1 | Downstream elastic buffer has a free slot |
| grant | output | NUM_IN | Registered one-hot owner of the output |
| xfer | output | NUM_IN | Per-input switch traversal enable for this cycle |

## Verification
The main pick is swept over every request pattern from every round-robin start position, reached from idle. This separates correct wrap-around order from a fixed-priority or off-by-one pointer.

The same request sweep is then repeated as a re-arbitration triggered by each possible holder's update. This shows whether the holder really drops to last priority, and whether an empty request set clears the grant.

With a grant held, every update pattern that leaves out the holder is applied while the requests change. A grant that moves under those conditions exposes a reload that is not gated by the holder.

A full sweep of the valid lines against both ready values checks the traversal enables. A reset applied in mid-packet confirms that the start position returns to input 0.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;

   typedef enum logic {
      PICK_SCAN = 1'b0,
      PICK_MASK = 1'b1
   } pick_style_e;

   function automatic int wrap_next(input int pos, input int n);
      return (pos >= n - 1) ? 0 : pos + 1;
   endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick
   import pkt_arb_pkg::*;
#(
   parameter int          NUM_IN = 5,
   parameter pick_style_e STYLE  = PICK_MASK,
   localparam int         IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic [NUM_IN-1:0] req,
   input  logic [IW-1:0]     start,
   output logic [NUM_IN-1:0] pick,
   output logic [IW-1:0]     pick_idx
);

   generate
      if (STYLE == PICK_SCAN) begin : g_scan
         always_comb begin
            logic found;
            int   pos;
            found    = 1'b0;
            pick     = '0;
            pick_idx = '0;
            for (int k = 0; k < NUM_IN; k++) begin
               pos = int'(start) + k;
               if (pos >= NUM_IN) pos = pos - NUM_IN;
               if (!found && req[pos]) begin
                  found     = 1'b1;
                  pick[pos] = 1'b1;
                  pick_idx  = IW'(pos);
               end
            end
         end
      end else begin : g_mask
         logic [NUM_IN-1:0] upper;
         logic [NUM_IN-1:0] masked;
         logic [NUM_IN-1:0] src;

         always_comb begin
            for (int i = 0; i < NUM_IN; i++) begin
               upper[i] = (i >= int'(start));
            end
            masked = req & upper;
            src    = (|masked) ? masked : req;
            pick   = src & (~src + NUM_IN'(1));
         end

         always_comb begin
            pick_idx = '0;
            for (int i = 0; i < NUM_IN; i++) begin
               if (pick[i]) pick_idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/arb_grant_state.sv
module arb_grant_state
   import pkt_arb_pkg::*;
#(
   parameter int  NUM_IN = 5,
   localparam int IW     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_IN-1:0] req,
   input  logic [NUM_IN-1:0] upd,
   input  logic [NUM_IN-1:0] pick,
   input  logic [IW-1:0]     pick_idx,
   output logic [NUM_IN-1:0] grant_q,
   output logic [IW-1:0]     start_q
);

   logic idle;
   logic holder_done;
   logic reload;

   assign idle        = (grant_q == '0);
   assign holder_done = |(upd & grant_q);
   assign reload      = idle || holder_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         grant_q <= '0;
         start_q <= '0;
      end else if (reload) begin
         grant_q <= pick;
         if (|req) start_q <= IW'(wrap_next(int'(pick_idx), NUM_IN));
      end
   end

   assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_q));

   assert_idle_pickup_R3: assert property (@(posedge clk) disable iff (rst)
      (grant_q == '0 && req != '0) |=> (grant_q != '0));

   assert_new_owner_requested_R4: assert property (@(posedge clk) disable iff (rst)
      (grant_q != '0 && !$stable(grant_q)) |-> (($past(req) & grant_q) != '0));

   assert_hold_R5_R6: assert property (@(posedge clk) disable iff (rst)
      (grant_q != '0 && (upd & grant_q) == '0) |=> $stable(grant_q));

   assert_release_idle_R8: assert property (@(posedge clk) disable iff (rst)
      ((upd & grant_q) != '0 && req == '0) |=> (grant_q == '0));

   assert_start_kept_R10: assert property (@(posedge clk) disable iff (rst)
      (req == '0) |=> $stable(start_q));

endmodule

// File: rtl/pkt_output_arbiter.sv
module pkt_output_arbiter
   import pkt_arb_pkg::*;
#(
   parameter int          NUM_IN = 5,
   parameter pick_style_e STYLE  = PICK_MASK
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NUM_IN-1:0] req,
   input  logic [NUM_IN-1:0] upd,
   input  logic [NUM_IN-1:0] in_valid,
   input  logic              out_ready,
   output logic [NUM_IN-1:0] grant,
   output logic [NUM_IN-1:0] xfer
);

   localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

   generate
      if (NUM_IN < 2) begin : g_bad_num_in
         $error("pkt_output_arbiter: NUM_IN must be at least 2");
      end
   endgenerate

   logic [NUM_IN-1:0] pick;
   logic [IW-1:0]     pick_idx;
   logic [IW-1:0]     start;

   arb_rr_pick #(
      .NUM_IN (NUM_IN),
      .STYLE  (STYLE)
   ) u_pick (
      .req      (req),
      .start    (start),
      .pick     (pick),
      .pick_idx (pick_idx)
   );

   arb_grant_state #(
      .NUM_IN (NUM_IN)
   ) u_state (
      .clk      (clk),
      .rst      (rst),
      .req      (req),
      .upd      (upd),
      .pick     (pick),
      .pick_idx (pick_idx),
      .grant_q  (grant),
      .start_q  (start)
   );

   generate
      for (genvar i = 0; i < NUM_IN; i++) begin : g_xfer
         assign xfer[i] = grant[i] & in_valid[i] & out_ready;
      end
   endgenerate

   assert_xfer_onehot_R9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(xfer));

   assert_xfer_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
      (!out_ready) |-> (xfer == '0));

endmodule

// File: tb/pkt_output_arbiter_test.sv
`timescale 1ns/1ps
module pkt_output_arbiter_test;

   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] req;
   logic [N-1:0] upd;
   logic [N-1:0] in_valid;
   logic         out_ready;
   logic [N-1:0] grant;
   logic [N-1:0] xfer;

   int  chk   = 0;
   int  err   = 0;
   bit  ended = 1'b0;

   always #2 clk = ~clk;

   pkt_output_arbiter #(.NUM_IN(N)) uut (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .upd       (upd),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .grant     (grant),
      .xfer      (xfer)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      chk++;
      if (act !== exp) begin
         err++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_pick(input logic [N-1:0] r, input int p);
      for (int k = 0; k < N; k++) begin
         int pos;
         pos = (p + k) % N;
         if (r[pos]) return N'(1) << pos;
      end
      return '0;
   endfunction

   task automatic go_idle();
      if (grant != '0) begin
         req = '0;
         upd = grant;
         tick();
         upd = '0;
      end
   endtask

   task automatic make_holder(input int h);
      go_idle();
      req = N'(1) << h;
      tick();
      req = '0;
   endtask

   task automatic set_start(input int p);
      make_holder((p + N - 1) % N);
      upd = grant;
      tick();
      upd = '0;
   endtask

   initial begin
      #(4 * 200000);
      if (!ended) begin
         ended = 1'b1;
         chk++;
         err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", chk, err);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; req = '0; upd = '0; in_valid = '0; out_ready = 1'b0;
      tick(); tick();
      check("R1 reset grant", grant, '0);
      rst = 1'b0;
      req = '1;
      tick();
      check("R1 start at input 0", grant, 5'b00001);
      go_idle();
      check("R8 release after reset pick", grant, '0);

      // R3 R4 R10: pick from idle, every start position and request pattern
      for (int p = 0; p < N; p++) begin
         for (int r = 0; r < (1 << N); r++) begin
            set_start(p);
            check("R10 idle after release", grant, '0);
            req = N'(r);
            tick();
            check($sformatf("R3_R4 idle pick start=%0d req=%b", p, r[N-1:0]),
                  grant, exp_pick(N'(r), p));
            go_idle();
         end
      end

      // R7 R8: re-arbitration on holder update
      for (int h = 0; h < N; h++) begin
         for (int r = 0; r < (1 << N); r++) begin
            make_holder(h);
            req = N'(r);
            upd = N'(1) << h;
            tick();
            upd = '0;
            check($sformatf("R7_R8 rearb holder=%0d req=%b", h, r[N-1:0]),
                  grant, exp_pick(N'(r), (h + 1) % N));
            go_idle();
         end
      end

      // R5 R6: holds while non-holders pulse update
      for (int h = 0; h < N; h++) begin
         make_holder(h);
         for (int u = 0; u < (1 << N); u++) begin
            if (u[h] == 1'b0) begin
               upd = N'(u);
               req = ~N'(u);
               tick();
               check($sformatf("R5_R6 hold holder=%0d upd=%b", h, u[N-1:0]),
                     grant, N'(1) << h);
            end
         end
         upd = '0;
         go_idle();
      end

      // R9: traversal enable in the same cycle
      make_holder(3);
      for (int v = 0; v < (1 << N); v++) begin
         for (int rd = 0; rd < 2; rd++) begin
            in_valid  = N'(v);
            out_ready = rd[0];
            #1;
            check($sformatf("R9 xfer valid=%b ready=%0d", v[N-1:0], rd),
                  xfer, (rd[0] && v[3]) ? 5'b01000 : 5'b00000);
         end
      end
      in_valid = '0; out_ready = 1'b0;

      // R1: reset mid-packet returns start to input 0
      make_holder(2);
      rst = 1'b1;
      tick();
      check("R1 reset mid-packet", grant, '0);
      rst = 1'b0;
      req = '1;
      tick();
      check("R1 start after mid reset", grant, 5'b00001);
      req = '0;

      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", chk, err);
      $finish;
   end

endmodule